// File: doc/BRIEF.md
# Word-Programmed Nonvolatile Array Controller

This block fronts a small on-chip nonvolatile word array and presents it on a simple single-request bus slave port with two windows. One window holds a handful of control and status registers: the automatic programming mode, a divider for the program-time base, a power-down control, an event status register and a write-one-to-clear register for that status. The other window reads and writes 32-bit words on a 4-byte stride. The array is held as a register array with no cell physics. Its pages are 128 bytes, and its topmost page carries initialization data and can never be written.

A word write to the memory window, with automatic word programming selected, stores the word and starts a timed erase/program cycle. That cycle counts strobes from a divider whose register holds the division factor minus one. When the programmed number of strobes has elapsed, the end-of-program flag rises in the status register. While the array is powered down, waking up or busy programming, memory accesses are refused and an error flag is latched. Reads take one wait cycle.

The controller runs as a five-state machine. OFF is powered down and is the reset state. WAKE counts the wake-up delay. IDLE is ready. RDWAIT is the array read wait. PROG is the erase/program cycle. The transitions are:
- off_to_wake: the power-down bit is cleared.
- wake_to_off and idle_to_off: the power-down bit is set.
- wake_to_idle: the wake delay has elapsed.
- idle_to_rdwait: a memory read is accepted.
- idle_to_prog: a memory write is accepted.
- rdwait_to_idle: this is unconditional.
- prog_to_idle: the last program strobe has arrived.

Top module: `eeprom_prog_ctrl`

## Requirements
- R1: After reset the controller is in OFF. The power-down register reads 1. The auto-program, divider and status registers read 0.
- R2: The register window decodes these offsets, which software depends on: 0x00C auto-program mode (bits 1:0), 0x014 divider, 0x018 power-down (bit 0), 0xFE0 status and 0xFE8 status clear. A register access is acknowledged in the cycle after it is sampled, with bus_err low. Reads of unmapped offsets and of 0xFE8 return 0.
- R3: Writing 0 to power-down moves OFF to WAKE on the next edge. Memory accesses are refused for WAKE_CYCLES cycles after that. The first access sampled WAKE_CYCLES+2 edges after the power-down write is accepted.
- R4: A memory access while powered down is acknowledged after one cycle with bus_err high, and the array is unchanged.
- R5: An accepted memory read is acknowledged two cycles after it is sampled, with the stored word and bus_err low.
- R6: With auto-program mode equal to 1, a write to an unlocked word is acknowledged after one cycle without error and stores the word. It then enters PROG. Status bit 2 (end of program) is set, and PROG is left, exactly PROG_TICKS×(divider+1) cycles after the write was sampled.
- R7: The divider holds the factor minus one. A value of 0 divides by one, and a value of d stretches the program cycle by the factor d+1.
- R8: During PROG, memory reads and writes are refused with bus_err, while register accesses are still served.
- R9: Writes to the top page, word index MEM_WORDS−32 and above, are refused and leave the word unchanged. Reads there are accepted.
- R10: When the auto-program mode is any value other than 1, memory writes are refused and the array is unchanged.
- R11: Writing 1 to bit 2 of the clear register clears the end-of-program bit, and writing 1 to bit 0 clears the error bit. An event arriving in the same cycle as the clear leaves its bit set.
- R12: Every refused memory access sets status bit 0 (error).
- R13: Setting power-down during PROG does not abort the cycle. The cycle completes and sets end of program, then the controller drops to OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Single-cycle access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_mem | input | 1 | 1 = memory window, 0 = register window |
| bus_addr | input | 12 | Byte offset within the selected window |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Access completion, one cycle high |
| bus_err | output | 1 | Access was refused, valid with bus_ack |
| bus_rdata | output | 32 | Read data, valid with bus_ack |

## Verification
Program completion and a write to the status clear register can land on the same clock edge. The same holds for a refused memory access and an error clear. The bench computes the exact completion edge from the divider and PROG_TICKS, then issues the clear write sampled at that edge. It expects the end-of-program bit to still read 1 afterwards, while a clear one cycle later must take effect. The edges on either side of completion are probed with memory reads: the access sampled on the completion edge must be refused, and the access one edge later must be accepted.

// File: rtl/epc_pkg.sv
package epc_pkg;
    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_WAKE   = 3'd1,
        ST_IDLE   = 3'd2,
        ST_RDWAIT = 3'd3,
        ST_PROG   = 3'd4
    } epc_state_e;

    localparam int unsigned BUS_AW = 12;
    localparam int unsigned BUS_DW = 32;

    // register window offsets, fixed because software decodes them
    localparam logic [BUS_AW-1:0] OFS_AUTO = 12'h00C;
    localparam logic [BUS_AW-1:0] OFS_DIV  = 12'h014;
    localparam logic [BUS_AW-1:0] OFS_PDN  = 12'h018;
    localparam logic [BUS_AW-1:0] OFS_STAT = 12'hFE0;
    localparam logic [BUS_AW-1:0] OFS_SCLR = 12'hFE8;

    localparam int unsigned BIT_EOP = 2;
    localparam int unsigned BIT_ERR = 0;

    localparam logic [1:0] AUTO_WORD = 2'd1;
endpackage

// File: rtl/epc_regfile.sv
module epc_regfile
    import epc_pkg::*;
#(
    parameter int unsigned DIV_W = 16   // must stay below 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BUS_AW-1:0] addr,
    input  logic [BUS_DW-1:0] wdata,
    input  logic              done_evt,
    input  logic              refuse_evt,
    output logic              auto_on,
    output logic [DIV_W-1:0]  div_val,
    output logic              pdn,
    output logic [BUS_DW-1:0] rdata
);
    logic [1:0]       auto_q;
    logic [DIV_W-1:0] div_q;
    logic             pdn_q;
    logic             eop_q;
    logic             err_q;
    logic             clr_eop;
    logic             clr_err;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[BUS_DW-1:DIV_W];

    assign clr_eop = wr_en && (addr == OFS_SCLR) && wdata[BIT_EOP];
    assign clr_err = wr_en && (addr == OFS_SCLR) && wdata[BIT_ERR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            auto_q <= '0;
            div_q  <= '0;
            pdn_q  <= 1'b1;
        end else if (wr_en) begin
            case (addr)
                OFS_AUTO: auto_q <= wdata[1:0];
                OFS_DIV:  div_q  <= wdata[DIV_W-1:0];
                OFS_PDN:  pdn_q  <= wdata[0];
                default:  ;
            endcase
        end
    end

    // event set takes priority over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eop_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            if (done_evt)        eop_q <= 1'b1;
            else if (clr_eop)    eop_q <= 1'b0;
            if (refuse_evt)      err_q <= 1'b1;
            else if (clr_err)    err_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_AUTO: rdata[1:0] = auto_q;
            OFS_DIV:  rdata[DIV_W-1:0] = div_q;
            OFS_PDN:  rdata[0] = pdn_q;
            OFS_STAT: begin
                rdata[BIT_EOP] = eop_q;
                rdata[BIT_ERR] = err_q;
            end
            default:  rdata = '0;
        endcase
    end

    assign auto_on = (auto_q == AUTO_WORD);
    assign div_val = div_q;
    assign pdn     = pdn_q;
endmodule

// File: rtl/epc_clkdiv.sv
module epc_clkdiv #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    // ">=" keeps the strobe alive if the divider shrinks mid-cycle
    assign tick = run && (cnt_q >= div_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!run || tick)   cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/epc_fsm.sv
module epc_fsm
    import epc_pkg::*;
#(
    parameter int unsigned WAKE_CYCLES = 12500,
    parameter int unsigned PROG_TICKS  = 4500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pdn,
    input  logic       auto_on,
    input  logic       acc_rd,
    input  logic       acc_wr,
    input  logic       wr_locked,
    input  logic       tick,
    output epc_state_e state,
    output logic       rd_go,
    output logic       wr_go,
    output logic       refuse,
    output logic       done_evt,
    output logic       rd_finish,
    output logic       prog_run
);
    localparam int unsigned WK_W = $clog2(WAKE_CYCLES + 1);
    localparam int unsigned PT_W = $clog2(PROG_TICKS + 1);
    localparam logic [WK_W-1:0] WAKE_LAST = WK_W'(WAKE_CYCLES - 1);
    localparam logic [PT_W-1:0] PROG_LAST = PT_W'(PROG_TICKS - 1);

    epc_state_e      state_q, state_d;
    logic [WK_W-1:0] wake_cnt;
    logic [PT_W-1:0] tick_cnt;
    logic            wake_end;
    logic            prog_end;
    logic            avail;

    assign wake_end = (state_q == ST_WAKE) && (wake_cnt == WAKE_LAST);
    assign prog_end = (state_q == ST_PROG) && tick && (tick_cnt == PROG_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:    if (!pdn) state_d = ST_WAKE;
            ST_WAKE:   if (pdn) state_d = ST_OFF;
                       else if (wake_end) state_d = ST_IDLE;
            ST_IDLE:   if (pdn) state_d = ST_OFF;
                       else if (rd_go) state_d = ST_RDWAIT;
                       else if (wr_go) state_d = ST_PROG;
            ST_RDWAIT: state_d = ST_IDLE;
            ST_PROG:   if (prog_end) state_d = ST_IDLE;
            default:   state_d = ST_OFF;
        endcase
    end

    always_comb begin
        avail     = (state_q == ST_IDLE) && !pdn;
        rd_go     = acc_rd && avail;
        wr_go     = acc_wr && avail && auto_on && !wr_locked;
        refuse    = (acc_rd || acc_wr) && !(rd_go || wr_go);
        done_evt  = prog_end;
        rd_finish = (state_q == ST_RDWAIT);
        prog_run  = (state_q == ST_PROG);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     wake_cnt <= '0;
        else if (state_q != ST_WAKE)    wake_cnt <= '0;
        else if (!wake_end)             wake_cnt <= wake_cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     tick_cnt <= '0;
        else if (state_q != ST_PROG)    tick_cnt <= '0;
        else if (tick)                  tick_cnt <= tick_cnt + 1'b1;
    end

    assign state = state_q;
endmodule

// File: rtl/epc_array.sv
module epc_array #(
    parameter int unsigned WORDS = 256,
    parameter int unsigned DW    = 32,
    localparam int unsigned IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [DW-1:0]    wdata,
    input  logic             re,
    input  logic [IDX_W-1:0] raddr,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (re) rdata <= cells[raddr];
    end
endmodule

// File: rtl/eeprom_prog_ctrl.sv
module eeprom_prog_ctrl
    import epc_pkg::*;
#(
    parameter int unsigned MEM_WORDS   = 256,   // at most 1024
    parameter int unsigned PAGE_BYTES  = 128,
    parameter int unsigned DIV_W       = 16,
    parameter int unsigned PROG_TICKS  = 4500,
    parameter int unsigned WAKE_CYCLES = 12500
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_req,
    input  logic        bus_we,
    input  logic        bus_mem,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic        bus_ack,
    output logic        bus_err,
    output logic [31:0] bus_rdata
);
    localparam int unsigned IDX_W      = $clog2(MEM_WORDS);
    localparam int unsigned PAGE_WORDS = PAGE_BYTES / 4;
    localparam int unsigned LOCK_BASE  = MEM_WORDS - PAGE_WORDS;

    logic              reg_acc, reg_wr, acc_rd, acc_wr;
    logic [IDX_W-1:0]  word_idx;
    logic              wr_locked;
    logic              auto_on, pdn_w, tick;
    logic [DIV_W-1:0]  div_val;
    logic [BUS_DW-1:0] reg_rdata, arr_rdata;
    epc_state_e        fsm_state;
    logic              rd_go, wr_go, refuse, done_evt, rd_finish, prog_run;
    logic              ack_q, err_q;
    logic [BUS_DW-1:0] rdata_q;

    assign reg_acc   = bus_req && !bus_mem;
    assign reg_wr    = reg_acc && bus_we;
    assign acc_rd    = bus_req && bus_mem && !bus_we;
    assign acc_wr    = bus_req && bus_mem && bus_we;
    assign word_idx  = bus_addr[IDX_W+1:2];
    assign wr_locked = (word_idx >= IDX_W'(LOCK_BASE));

    epc_regfile #(.DIV_W(DIV_W)) rf_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .done_evt   (done_evt),
        .refuse_evt (refuse),
        .auto_on    (auto_on),
        .div_val    (div_val),
        .pdn        (pdn_w),
        .rdata      (reg_rdata)
    );

    epc_clkdiv #(.DIV_W(DIV_W)) div_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (prog_run),
        .div_val (div_val),
        .tick    (tick)
    );

    epc_fsm #(
        .WAKE_CYCLES (WAKE_CYCLES),
        .PROG_TICKS  (PROG_TICKS)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pdn       (pdn_w),
        .auto_on   (auto_on),
        .acc_rd    (acc_rd),
        .acc_wr    (acc_wr),
        .wr_locked (wr_locked),
        .tick      (tick),
        .state     (fsm_state),
        .rd_go     (rd_go),
        .wr_go     (wr_go),
        .refuse    (refuse),
        .done_evt  (done_evt),
        .rd_finish (rd_finish),
        .prog_run  (prog_run)
    );

    epc_array #(.WORDS(MEM_WORDS), .DW(BUS_DW)) arr_i (
        .clk   (clk),
        .we    (wr_go),
        .waddr (word_idx),
        .wdata (bus_wdata),
        .re    (rd_go),
        .raddr (word_idx),
        .rdata (arr_rdata)
    );

    // response stage: registers after one cycle, reads after the wait cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            ack_q <= reg_acc || ((acc_rd || acc_wr) && !rd_go) || rd_finish;
            err_q <= refuse;
            if (rd_finish)                rdata_q <= arr_rdata;
            else if (reg_acc && !bus_we)  rdata_q <= reg_rdata;
            else                          rdata_q <= '0;
        end
    end

    assign bus_ack   = ack_q;
    assign bus_err   = err_q;
    assign bus_rdata = rdata_q;
endmodule

// File: rtl/epc_chk.sv
module epc_chk
    import epc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_req,
    input logic        bus_we,
    input logic        bus_mem,
    input logic [11:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic        bus_ack,
    input logic        bus_err,
    input epc_state_e  state,
    input logic        pdn,
    input logic        eop,
    input logic        done_evt
);
    // R2
    reg_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_mem |=> bus_ack && !bus_err);

    // R4
    off_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_mem && state == ST_OFF |=> bus_ack && bus_err);

    // R5
    rd_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_mem && !bus_we && state == ST_IDLE && !pdn
        |=> !bus_ack ##1 (bus_ack && !bus_err));

    // R6
    eop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eop) |-> $past(state) == ST_PROG);

    // R8
    prog_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_mem && state == ST_PROG |=> bus_ack && bus_err);

    // R13
    prog_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state) == ST_PROG && state != ST_PROG |-> state == ST_IDLE);

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> eop);

    // R11
    eop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_mem && bus_we && bus_addr == OFS_SCLR
        && bus_wdata[BIT_EOP] && !done_evt |=> !eop);

    // R12
    err_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_ack);
endmodule

bind eeprom_prog_ctrl epc_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_mem   (bus_mem),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .bus_err   (bus_err),
    .state     (fsm_state),
    .pdn       (pdn_w),
    .eop       (rf_i.eop_q),
    .done_evt  (done_evt)
);

// File: tb/eeprom_prog_ctrl_tb_top.sv
`timescale 1ns/1ps
module eeprom_prog_ctrl_tb_top;
    localparam int PT    = 6;
    localparam int WK    = 5;
    localparam int WORDS = 256;
    localparam int PAGEW = 32;
    localparam logic [11:0] A_AUTO = 12'h00C, A_DIV = 12'h014, A_PDN = 12'h018,
                            A_STAT = 12'hFE0, A_SCLR = 12'hFE8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0, bus_mem = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack, bus_err;
    logic [31:0] bus_rdata;

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int nvec = 0, nfail = 0, last_edge = 0;
    bit finished = 1'b0;
    logic [31:0] model [WORDS];
    bit          valid [WORDS];

    eeprom_prog_ctrl #(
        .MEM_WORDS(WORDS), .PAGE_BYTES(128), .DIV_W(16),
        .PROG_TICKS(PT), .WAKE_CYCLES(WK)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_mem(bus_mem), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata)
    );

    function automatic int prog_len(int dv);
        return PT * (dv + 1);
    endfunction

    function automatic bit is_locked(int idx);
        return idx >= WORDS - PAGEW;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic we, input logic mem, input logic [11:0] a,
                        input logic [31:0] d, input int at,
                        output int lat, output logic [31:0] rd, output logic er);
        @(negedge clk);
        if (at >= 0) begin
            while (cyc < at - 1) @(negedge clk);
            if (cyc != at - 1) check("timing target missed", 32'(cyc + 1), 32'(at));
        end
        bus_req = 1'b1; bus_we = we; bus_mem = mem; bus_addr = a; bus_wdata = d;
        last_edge = cyc + 1;
        @(negedge clk);
        bus_req = 1'b0;
        lat = 1;
        while (!bus_ack && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        rd = bus_rdata;
        er = bus_err;
    endtask

    task automatic reg_w(input logic [11:0] a, input logic [31:0] d);
        int l; logic [31:0] r; logic e;
        xfer(1'b1, 1'b0, a, d, -1, l, r, e);
    endtask

    task automatic reg_r(input logic [11:0] a, output logic [31:0] d);
        int l; logic e;
        xfer(1'b0, 1'b0, a, 32'h0, -1, l, d, e);
    endtask

    task automatic mem_w(input int idx, input logic [31:0] d, input int at,
                         output logic er);
        int l; logic [31:0] r;
        xfer(1'b1, 1'b1, 12'(idx * 4), d, at, l, r, er);
    endtask

    task automatic mem_r(input int idx, input int at, output logic [31:0] d,
                         output logic er, output int lat);
        xfer(1'b0, 1'b1, 12'(idx * 4), 32'h0, at, lat, d, er);
    endtask

    task automatic wait_prog(string tag);
        logic [31:0] s;
        s = '0;
        for (int i = 0; i < 60; i++) begin
            reg_r(A_STAT, s);
            if (s[2]) break;
        end
        check(tag, 32'(s[2]), 32'd1);
        reg_w(A_SCLR, 32'h5);
    endtask

    // probes one program cycle at a chosen offset from its start edge
    task automatic prog_probe(int idx, logic [31:0] d, int dv, int ofs, bit expect_ok);
        logic e; logic [31:0] r; int l, t0;
        mem_w(idx, d, -1, e);
        check("R6 write accepted", 32'(e), 32'd0);
        model[idx] = d; valid[idx] = 1'b1;
        t0 = last_edge;
        mem_r(idx, t0 + prog_len(dv) + ofs, r, e, l);
        if (expect_ok) begin
            check("R7 accepted right after program end", 32'(e), 32'd0);
            check("R5 read latency", 32'(l), 32'd2);
            check("R6 stored word", r, d);
            reg_r(A_STAT, r);
            check("R6 eop set", 32'(r[2]), 32'd1);
            reg_w(A_SCLR, 32'h5);
        end else begin
            check("R8 refused on completion edge", 32'(e), 32'd1);
            wait_prog("R6 eop after program");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, v0;
        logic e;
        int l, t0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < WORDS; i++) valid[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_r(A_AUTO, r); check("R1 auto reset", r, 32'h0);
        reg_r(A_DIV, r);  check("R1 div reset", r, 32'h0);
        reg_r(A_PDN, r);  check("R1 pdn reset", r, 32'h1);
        reg_r(A_STAT, r); check("R1 status reset", r, 32'h0);

        // R4 / R12 access while powered down
        mem_r(3, -1, r, e, l);
        check("R4 refused when off", 32'(e), 32'd1);
        check("R4 refusal latency", 32'(l), 32'd1);
        reg_r(A_STAT, r); check("R12 err flag", r, 32'h1);
        reg_w(A_SCLR, 32'h1);
        reg_r(A_STAT, r); check("R11 err cleared", r, 32'h0);

        // R2 register window
        reg_w(A_AUTO, 32'h1);  reg_r(A_AUTO, r); check("R2 auto readback", r, 32'h1);
        reg_w(A_DIV, 32'h3);   reg_r(A_DIV, r);  check("R2 div readback", r, 32'h3);
        reg_r(12'h100, r);     check("R2 unmapped reads 0", r, 32'h0);
        reg_r(A_SCLR, r);      check("R2 clear reg reads 0", r, 32'h0);
        begin
            int ll; logic [31:0] rr; logic ee;
            xfer(1'b0, 1'b0, A_DIV, 32'h0, -1, ll, rr, ee);
            check("R2 register latency", 32'(ll), 32'd1);
            check("R2 register no err", 32'(ee), 32'd0);
        end

        // R3 wake window edges
        reg_w(A_PDN, 32'h0);
        t0 = last_edge;
        mem_r(0, t0 + 1 + WK, r, e, l);
        check("R3 refused during wake", 32'(e), 32'd1);
        reg_w(A_SCLR, 32'h1);
        reg_w(A_PDN, 32'h1);
        reg_w(A_PDN, 32'h0);
        t0 = last_edge;
        mem_r(0, t0 + 2 + WK, r, e, l);
        check("R3 accepted after wake", 32'(e), 32'd0);
        check("R3 read latency", 32'(l), 32'd2);

        // R6 / R7 / R8 program duration at two divider settings
        reg_w(A_DIV, 32'h0);
        prog_probe(5, 32'hA5A5_0001, 0, 0, 1'b0);
        prog_probe(5, 32'hA5A5_0002, 0, 1, 1'b1);
        reg_w(A_DIV, 32'h2);
        prog_probe(6, 32'h5A5A_0003, 2, 0, 1'b0);
        prog_probe(6, 32'h5A5A_0004, 2, 1, 1'b1);

        // R8 register access served mid-program, memory refused
        mem_w(7, 32'h0000_7777, -1, e);
        model[7] = 32'h0000_7777; valid[7] = 1'b1;
        reg_r(A_DIV, r); check("R8 register read during program", r, 32'h2);
        mem_w(8, 32'h1, -1, e);
        check("R8 write refused during program", 32'(e), 32'd1);
        wait_prog("R8 program completes");

        // R11 clear in the completion cycle: set wins
        reg_w(A_DIV, 32'h0);
        mem_w(9, 32'hC0DE_0009, -1, e);
        model[9] = 32'hC0DE_0009; valid[9] = 1'b1;
        t0 = last_edge;
        begin
            int ll; logic [31:0] rr; logic ee;
            xfer(1'b1, 1'b0, A_SCLR, 32'h4, t0 + prog_len(0), ll, rr, ee);
        end
        reg_r(A_STAT, r); check("R11 set wins over clear", 32'(r[2]), 32'd1);
        reg_w(A_SCLR, 32'h0);
        reg_r(A_STAT, r); check("R11 zero write keeps eop", 32'(r[2]), 32'd1);
        reg_w(A_SCLR, 32'h4);
        reg_r(A_STAT, r); check("R11 eop cleared", 32'(r[2]), 32'd0);

        // R9 locked top page
        mem_r(WORDS - 6, -1, v0, e, l);
        check("R9 read of top page accepted", 32'(e), 32'd0);
        mem_w(WORDS - 6, ~v0, -1, e);
        check("R9 top page write refused", 32'(e), 32'd1);
        mem_r(WORDS - 6, -1, r, e, l);
        check("R9 top page unchanged", r, v0);
        mem_w(WORDS - PAGEW - 1, 32'h1234_5678, -1, e);
        check("R9 last unlocked word accepted", 32'(e), 32'd0);
        model[WORDS - PAGEW - 1] = 32'h1234_5678; valid[WORDS - PAGEW - 1] = 1'b1;
        wait_prog("R9 program completes");

        // R10 auto mode other than 1
        reg_w(A_AUTO, 32'h0);
        mem_w(5, 32'hDEAD_0000, -1, e);
        check("R10 refused with auto 0", 32'(e), 32'd1);
        reg_w(A_AUTO, 32'h2);
        mem_w(5, 32'hDEAD_0002, -1, e);
        check("R10 refused with auto 2", 32'(e), 32'd1);
        mem_r(5, -1, r, e, l);
        check("R10 word unchanged", r, model[5]);
        reg_w(A_AUTO, 32'h1);
        reg_w(A_SCLR, 32'h1);

        // R4 write while off leaves array unchanged
        reg_w(A_PDN, 32'h1);
        mem_w(5, 32'hBAD0_BAD0, -1, e);
        check("R4 write refused when off", 32'(e), 32'd1);
        reg_w(A_PDN, 32'h0);
        repeat (WK + 4) @(negedge clk);
        mem_r(5, -1, r, e, l);
        check("R4 array unchanged", r, model[5]);
        reg_w(A_SCLR, 32'h1);

        // R13 power-down during program
        mem_w(10, 32'hFACE_000A, -1, e);
        model[10] = 32'hFACE_000A; valid[10] = 1'b1;
        reg_w(A_PDN, 32'h1);
        repeat (prog_len(0) + 4) @(negedge clk);
        reg_r(A_STAT, r); check("R13 program completed", 32'(r[2]), 32'd1);
        mem_r(10, -1, r, e, l);
        check("R13 off after program", 32'(e), 32'd1);
        reg_w(A_SCLR, 32'h5);
        reg_w(A_PDN, 32'h0);
        repeat (WK + 4) @(negedge clk);
        mem_r(10, -1, r, e, l);
        check("R13 word programmed", r, 32'hFACE_000A);

        // random mix
        for (int n = 0; n < 60; n++) begin
            int idx;
            logic [31:0] d;
            idx = int'($urandom_range(WORDS - 1, 0));
            d = $urandom;
            if ($urandom_range(1, 0) == 1) begin
                mem_w(idx, d, -1, e);
                check("R9 random write refusal", 32'(e), 32'(is_locked(idx)));
                if (!is_locked(idx) && !e) begin
                    model[idx] = d; valid[idx] = 1'b1;
                    wait_prog("R6 random program");
                end else begin
                    reg_w(A_SCLR, 32'h1);
                end
            end else begin
                mem_r(idx, -1, r, e, l);
                check("R5 random read ok", 32'(e), 32'd0);
                check("R5 random latency", 32'(l), 32'd2);
                if (valid[idx]) check("R5 random read data", r, model[idx]);
            end
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule